// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, in which entries are located by what they hold rather than by where they sit. A search presents a comparand and a per-bit care mask. Every stored entry is checked against the comparand at once, and only the bit columns whose mask bit is 1 take part. The result is a one-hot-per-entry hit vector, a summary hit flag, the index of the lowest hitting entry, and the contents of that entry.

Writes carry data only. The store places each new word in the lowest-numbered empty entry and marks it occupied. When no entry is empty the write is dropped and a full indication is shown. A separate clear request frees one entry by index, so that later writes can use it again. Typical use is a small lookup table: load entries, search with a partial key, and read back the whole word through the result port.

Top module: `masked_cam`

## Requirements
- R1: While the synchronised reset is active and after its release, every entry is empty, `full` is 0, `match_vec` is all zeros, `any_match` is 0, `match_idx` is 0 and `rd_data` is 0.
- R2: A write with `wr_en`=1 stores `wr_data` in the lowest-numbered empty entry and marks that entry occupied on the same clock edge.
- R3: `full` is 1 exactly when every entry is occupied. A write presented while `full` is 1 changes no entry.
- R4: On the clock edge at which `srch_en` is 1, bit i of `match_vec` becomes 1 when entry i is occupied and `((entry_i ^ arg) & key) == 0`, and 0 otherwise. Without `srch_en`, all search outputs hold their values.
- R5: With `key` all ones every bit is compared. With `key` all zeros every occupied entry hits.
- R6: An empty entry never sets its `match_vec` bit, whatever it once held.
- R7: `clr_en`=1 empties entry `clr_idx` on the clock edge, and the next write reuses the lowest empty entry, which may be the one just cleared.
- R8: `any_match` is 1 when any `match_vec` bit is 1. `match_idx` is the lowest index whose `match_vec` bit is 1, or 0 when none is.
- R9: `rd_data` is the content, at the search edge, of the entry named by `match_idx`. It is 0 when `any_match` is 0, and it holds until the next search.
- R10: A search, write and clear in the same cycle all act on the state before the edge. The write picks its entry from that state, the search does not see the new word, and a clear of the entry the write picks leaves it occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store `wr_data` in a free entry |
| wr_data | input | WIDTH | Word to store |
| clr_en | input | 1 | Empty the entry named by `clr_idx` |
| clr_idx | input | IDX_W | Entry to empty |
| srch_en | input | 1 | Run a search this cycle |
| arg | input | WIDTH | Comparand |
| key | input | WIDTH | Care mask, 1 = compare this bit |
| full | output | 1 | All entries occupied |
| match_vec | output | WORDS | Per-entry hit result of the last search |
| any_match | output | 1 | Last search hit at least one entry |
| match_idx | output | IDX_W | Lowest hitting entry of the last search |
| rd_data | output | WIDTH | Content of entry `match_idx` at the last search |

## Verification
The hardest conditions to reach from the ports are an entry that has been cleared but still holds a word equal to the comparand, and a write that coincides with a search or a clear. The stimulus reaches the first by filling the store, clearing chosen entries and then searching with the old contents and with an all-zero mask. It reaches the second by issuing writes, clears and searches in one cycle, in directed steps and in a random phase. The random phase draws data from a narrow value set, so that repeated words and multiple hits are common.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cam_lowest_sel.sv
`timescale 1ns/1ps
module cam_lowest_sel #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cam_store.sv
`timescale 1ns/1ps
module cam_store #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IW    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         clr_en,
  input  logic [IW-1:0]                clr_idx,
  output logic [WORDS-1:0][WIDTH-1:0]  words,
  output logic [WORDS-1:0]             valid,
  output logic                         full
);
  logic [WORDS-1:0] valid_q, valid_d, wr_sel;
  logic             free_found;
  logic [IW-1:0]    free_idx;

  cam_lowest_sel #(.N(WORDS), .IW(IW)) u_free (
    .req   (~valid_q),
    .found (free_found),
    .idx   (free_idx)
  );

  always_comb begin
    valid_d = valid_q;
    wr_sel  = '0;
    if (clr_en && (int'(clr_idx) < int'(WORDS))) valid_d[clr_idx] = 1'b0;
    if (wr_en && free_found) begin
      valid_d[free_idx] = 1'b1;
      wr_sel[free_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WIDTH-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_sel[g]) word_q <= wr_data;
    end
    assign words[g] = word_q;
  end

  assign valid = valid_q;
  assign full  = &valid_q;
endmodule

// File: rtl/cam_compare.sv
`timescale 1ns/1ps
module cam_compare #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [WORDS-1:0]            valid,
  input  logic [WIDTH-1:0]            arg,
  input  logic [WIDTH-1:0]            key,
  output logic [WORDS-1:0]            hit
);
  for (genvar g = 0; g < WORDS; g++) begin : g_line
    assign hit[g] = valid[g] & ~|((words[g] ^ arg) & key);
  end
endmodule

// File: rtl/masked_cam.sv
`timescale 1ns/1ps
module masked_cam #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = cam_pkg::idx_w(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] arg,
  input  logic [WIDTH-1:0] key,
  output logic             full,
  output logic [WORDS-1:0] match_vec,
  output logic             any_match,
  output logic [IDX_W-1:0] match_idx,
  output logic [WIDTH-1:0] rd_data
);
  localparam int unsigned NS = cam_pkg::SYNC_STAGES;

  // reset: asserted at once, released after NS clock edges
  logic [NS-1:0] rst_pipe;
  logic          rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[NS-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[NS-1];

  logic [WORDS-1:0][WIDTH-1:0] st_words;
  logic [WORDS-1:0]            st_valid;
  logic [WORDS-1:0]            hit;
  logic                        hit_found;
  logic [IDX_W-1:0]            hit_idx;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IW(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .words   (st_words),
    .valid   (st_valid),
    .full    (full)
  );

  cam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
    .words (st_words),
    .valid (st_valid),
    .arg   (arg),
    .key   (key),
    .hit   (hit)
  );

  cam_lowest_sel #(.N(WORDS), .IW(IDX_W)) u_hit_sel (
    .req   (hit),
    .found (hit_found),
    .idx   (hit_idx)
  );

  logic [WORDS-1:0] mv_q, mv_d;
  logic             any_q, any_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WIDTH-1:0] rd_q, rd_d;

  always_comb begin
    mv_d  = mv_q;
    any_d = any_q;
    idx_d = idx_q;
    rd_d  = rd_q;
    if (srch_en) begin
      mv_d  = hit;
      any_d = hit_found;
      idx_d = hit_idx;
      rd_d  = hit_found ? st_words[hit_idx] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mv_q  <= '0;
      any_q <= 1'b0;
      idx_q <= '0;
      rd_q  <= '0;
    end else if (srch_en) begin
      mv_q  <= mv_d;
      any_q <= any_d;
      idx_q <= idx_d;
      rd_q  <= rd_d;
    end
  end

  assign match_vec = mv_q;
  assign any_match = any_q;
  assign match_idx = idx_q;
  assign rd_data   = rd_q;
endmodule

// File: rtl/masked_cam_chk.sv
`timescale 1ns/1ps
module masked_cam_chk #(
  parameter int unsigned WORDS = 8,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             clr_en,
  input logic             srch_en,
  input logic             full,
  input logic [WORDS-1:0] valid,
  input logic [WORDS-1:0] match_vec,
  input logic             any_match,
  input logic [IDX_W-1:0] match_idx,
  input logic [WIDTH-1:0] rd_data
);
  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    any_match == (|match_vec)); // R8

  AST_LOWEST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> (match_vec[match_idx] &&
      ((match_vec & ((WORDS'(1) << match_idx) - WORDS'(1))) == '0))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> $stable(match_vec) && $stable(rd_data)); // R4

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> ((match_vec & ~$past(valid)) == '0)); // R6

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !clr_en) |=> full && $stable(valid)); // R3

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !any_match |-> (rd_data == '0)); // R9
endmodule

bind masked_cam masked_cam_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .clr_en    (clr_en),
  .srch_en   (srch_en),
  .full      (full),
  .valid     (st_valid),
  .match_vec (match_vec),
  .any_match (any_match),
  .match_idx (match_idx),
  .rd_data   (rd_data)
);

// File: tb/masked_cam_tb.sv
`timescale 1ns/1ps
module masked_cam_tb;
  localparam int unsigned WORDS = 8;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned IW    = cam_pkg::idx_w(WORDS);
  localparam logic [WIDTH-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, clr_en = 1'b0, srch_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0, arg = '0, key = '0;
  logic [IW-1:0]    clr_idx = '0;
  logic             full, any_match;
  logic [WORDS-1:0] match_vec;
  logic [IW-1:0]    match_idx;
  logic [WIDTH-1:0] rd_data;

  always #10 clk = ~clk;

  masked_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
    .clk, .rst_n, .wr_en, .wr_data, .clr_en, .clr_idx, .srch_en, .arg, .key,
    .full, .match_vec, .any_match, .match_idx, .rd_data
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] m_mem [WORDS];
  logic [WORDS-1:0] m_vld;
  logic [WORDS-1:0] e_mv;
  logic             e_any;
  logic [IW-1:0]    e_idx;
  logic [WIDTH-1:0] e_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [WORDS-1:0] v);
    for (int i = 0; i < WORDS; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [WORDS-1:0] hits(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] h = '0;
    for (int i = 0; i < WORDS; i++) h[i] = m_vld[i] && (((m_mem[i] ^ a) & k) == '0);
    return h;
  endfunction

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input bit w, input logic [WIDTH-1:0] wd, input bit c, input logic [IW-1:0] ci,
                      input bit s, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k, input string tag);
    int fi, hi;
    wr_en = w; wr_data = wd; clr_en = c; clr_idx = ci; srch_en = s; arg = a; key = k;
    if (s) begin
      e_mv  = hits(a, k);
      hi    = lowest(e_mv);
      e_any = (hi >= 0);
      e_idx = e_any ? IW'(hi) : '0;
      e_rd  = e_any ? m_mem[hi] : '0;
    end
    fi = lowest(~m_vld);
    if (c) m_vld[ci] = 1'b0;
    if (w && fi >= 0) begin m_mem[fi] = wd; m_vld[fi] = 1'b1; end
    @(negedge clk);
    chk({tag, " R4 match_vec"}, 32'(match_vec), 32'(e_mv));
    chk({tag, " R8 any_match"}, 32'(any_match), 32'(e_any));
    chk({tag, " R8 match_idx"}, 32'(match_idx), 32'(e_idx));
    chk({tag, " R9 rd_data"},   32'(rd_data),   32'(e_rd));
    chk({tag, " R3 full"},      32'(full),      32'(&m_vld));
    wr_en = 0; clr_en = 0; srch_en = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_vld = '0; e_mv = '0; e_any = 0; e_idx = '0; e_rd = '0;
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 full", 32'(full), 0);
    chk("R1 match_vec", 32'(match_vec), 0);
    chk("R1 any_match", 32'(any_match), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
    step(0, '0, 0, '0, 1, '0, '0, "R1 empty search");

    // R2 fill in order, R10 search same cycle as write sees old state
    for (int i = 0; i < WORDS; i++)
      step(1, 16'h1000 + 16'(i), 0, '0, 1, 16'h1000 + 16'(i), ONES, "R10 wr+srch");
    for (int i = 0; i < WORDS; i++)
      step(0, '0, 0, '0, 1, 16'h1000 + 16'(i), ONES, "R2 slot order");
    // R3 write refused when full
    step(1, 16'hBEEF, 0, '0, 0, '0, '0, "R3 refused wr");
    step(0, '0, 0, '0, 1, 16'hBEEF, ONES, "R3 no store");
    // R5 masks
    step(0, '0, 0, '0, 1, '0, '0, "R5 key zero");
    step(0, '0, 0, '0, 1, 16'h0004, 16'h000F, "R5 partial");
    step(0, '0, 0, '0, 1, 16'h1003, ONES, "R5 exact");
    // R6/R7 clear then search the old word, then reuse
    step(0, '0, 1, IW'(3), 0, '0, '0, "R7 clear");
    step(0, '0, 0, '0, 1, 16'h1003, ONES, "R6 cleared no hit");
    step(0, '0, 1, IW'(1), 1, '0, '0, "R10 clr+srch");
    step(1, 16'h2222, 0, '0, 1, 16'h2222, ONES, "R7 reuse");
    step(0, '0, 0, '0, 1, 16'h2222, ONES, "R7 reuse lowest");
    // R10 clear valid word while write fills another; clear of empty chosen slot
    step(1, 16'h3333, 1, IW'(3), 0, '0, '0, "R10 clr wins none");
    step(0, '0, 1, IW'(0), 0, '0, '0, "R7 clear 0");
    step(1, 16'h4444, 1, IW'(0), 0, '0, '0, "R10 wr beats clr");
    step(0, '0, 0, '0, 1, '0, '0, "R10 result");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 8);
      logic [WIDTH-1:0] d = 16'hA500 | 16'($urandom % 12);
      logic [WIDTH-1:0] k;
      logic [WIDTH-1:0] a;
      case ($urandom % 3)
        0: k = ONES;
        1: k = '0;
        default: k = 16'($urandom);
      endcase
      a = ($urandom % 2) ? m_mem[$urandom % WORDS] : d;
      step(r < 4, d, (r == 4) || (r == 7), IW'($urandom % WORDS), (r >= 3), a, k, "R4 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule